// File: doc/BRIEF.md
# ARINC 429 Transmit FIFO and Serializer

This block takes words from a 16-bit host bus, two halves per word, and holds up to eight of them in a queue. It sends them as bipolar return-to-zero serial data on two line-level outputs: a positive drive and a negative drive. An external analog driver turns these into the differential line levels. The host writes the first half with one strobe and the second half with another. The second strobe reorders the two halves into serial bit order and pushes the 31-bit result into the queue.

When transmit enable is high, the serializer takes words from the queue one after another. Each word is 24 or 31 data bits followed by a parity bit that the block generates. A fixed four-bit null gap follows each word. The bit period is 10 or 80 master clocks. A bit-rate clock output shows the active bit phase, and an empty flag tells the host when the queue may be refilled. The load strobes are plain one-cycle pulses with no back-pressure. A push into a full queue is dropped, so the host must count the words it writes. Loads are accepted only while transmit enable is low.

Top module: `a429_tx`

## Requirements
- R1: A high `load_first` captures `bus_in` into the first-half holding register, and a later pulse overwrites it. A high `load_second` combines the holding register with the current `bus_in` and pushes the word. `tx_empty` falls after the clock edge that performs the push.
- R2: With `fmt_short`=0, serial bit k (k=1 is sent first) is taken as follows. Bits 1..8 come from first[0..7]. Bits 9..13 come from first[11..15]. Bits 14..29 come from second[0..15]. Bits 30 and 31 come from first[9] and first[10]. first[8] is discarded.
- R3: With `fmt_short`=1, serial bits 1..8 come from first[0..7] and bits 9..24 come from second[0..15]. first[15:8] is discarded.
- R4: The queue holds eight words. A second-half strobe while eight words are queued is dropped, and only the first eight words are sent.
- R5: Both load strobes have no effect while `tx_en` is high.
- R6: A word is sent as N data bits, with N=24 when `fmt_short`=1 and N=31 otherwise, followed by one parity bit. With `par_even`=0 the parity makes the count of ones in the N+1 bits odd. With `par_even`=1 it makes that count even.
- R7: In the first half of each bit time, `line_pos` is high for a 1 and `line_neg` is high for a 0. Both are low in the second half, and they are never high together.
- R8: A bit time lasts 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1. The first bit's time starts at the clock edge that sees `tx_en` high while words are queued.
- R9: Each word is followed by four bit times with both line outputs low. The next queued word starts right after the gap, so one word occupies 29 or 36 bit times.
- R10: `tx_empty` is high after reset and low while any word is queued or in flight. It rises exactly at the end of the last word's gap, which is M*(N+5) bit times after the start for M queued words.
- R11: When `tx_en` goes low, both line outputs go low in the same cycle. The word in flight is discarded, and the words still queued are kept.
- R12: `bit_clk` is high during the first half of every bit time, including gap bits, while a word or its gap is being sent. It is low otherwise.
- R13: An active-low `rst_n` empties the queue and stops the serializer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 16 | Host data half-word |
| load_first | input | 1 | One-cycle strobe that captures the first half |
| load_second | input | 1 | One-cycle strobe that captures the second half and pushes the word |
| tx_en | input | 1 | Transmit enable; loads are accepted only while it is low |
| fmt_short | input | 1 | 1 = 24 data bits, 0 = 31 data bits |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rate_slow | input | 1 | 1 = bit time of 80 clocks, 0 = bit time of 10 clocks |
| line_pos | output | 1 | Positive-level line drive |
| line_neg | output | 1 | Negative-level line drive |
| bit_clk | output | 1 | Bit-rate clock, high in the first half of each active bit |
| tx_empty | output | 1 | Queue empty and serializer idle |

## Verification
The first bit time begins at the edge that sees `tx_en` high. The bench raises `tx_en` at a falling edge and counts cycle offsets from the next falling edge. It therefore expects bit b, phase p at offset b*D+p, with D equal to 10 or 80. `tx_empty` must still be low at offset M*(N+5)*D-1 and high at offset M*(N+5)*D. The bench checks both samples. A push shows on `tx_empty` one edge after the second strobe. A drop of `tx_en` acts on the line outputs without any register in the path, so the bench checks it 1 ns after the drop, with no clock edge in between. All sampling happens at falling edges, and every expected waveform is computed from the bit offset arithmetic.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 31;
  localparam int SHORT_BITS = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_GAP  = 2'd2
  } ser_state_e;

  // Long format: reorder the two bus halves into serial order (index 0 is sent first)
  function automatic logic [WORD_W-1:0] pack_long(input logic [HALF_W-1:0] first,
                                                  input logic [HALF_W-1:0] second);
    return {first[10], first[9], second[15:0], first[15:11], first[7:0]};
  endfunction

  // Short format: label byte followed by the 16 bits of the second half
  function automatic logic [WORD_W-1:0] pack_short(input logic [HALF_W-1:0] first,
                                                   input logic [HALF_W-1:0] second);
    return {{(WORD_W-SHORT_BITS){1'b0}}, second, first[7:0]};
  endfunction

endpackage

// File: rtl/a429_tx_loader.sv
module a429_tx_loader
  import a429_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] bus_in,
  input  logic              strobe_first,
  input  logic              strobe_second,
  input  logic              accept,
  input  logic              queue_full,
  input  logic              short_fmt,
  output logic              push,
  output logic [WORD_W-1:0] word
);

  logic [HALF_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= '0;
    end else if (accept && strobe_first) begin
      first_q <= bus_in;
    end
  end

  always_comb begin
    push = accept && strobe_second && !queue_full;
    word = short_fmt ? pack_short(first_q, bus_in) : pack_long(first_q, bus_in);
  end

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int W     = 31,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] fill
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push;
  logic             do_pop;

  always_comb begin
    empty   = (cnt == '0);
    full    = (cnt == CNT_W'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    dout    = mem[rd_ptr];
    fill    = cnt;
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/a429_tx_rate.sv
module a429_tx_rate #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  localparam int CW = $clog2(DIV_SLOW)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic slow,
  output logic first_half,
  output logic bit_end
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic [CW-1:0] half;

  always_comb begin
    lim        = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    half       = slow ? CW'(DIV_SLOW / 2) : CW'(DIV_FAST / 2);
    bit_end    = (cnt == lim);
    first_half = (cnt < half);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      cnt <= '0;
    end else if (bit_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              short_fmt,
  input  logic              even_par,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_word,
  input  logic              first_half,
  input  logic              bit_end,
  output logic              pop,
  output logic              hold,
  output logic              idle,
  output logic              line_pos,
  output logic              line_neg,
  output logic              bit_clk
);

  localparam int IDX_W = $clog2(WORD_W + 1);
  localparam int GAP_W = $clog2(GAP_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(WORD_W);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(SHORT_BITS);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_BITS - 1);

  ser_state_e        st;
  logic [WORD_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  par_idx;
  logic [GAP_W-1:0]  gap_cnt;
  logic              par_bit;
  logic              cur_bit;
  logic              gap_done;
  logic              active;

  always_comb begin
    par_idx  = short_fmt ? IDX_SHORT : IDX_LONG;
    gap_done = (st == ST_GAP) && bit_end && (gap_cnt == GAP_LAST);
    pop      = tx_en && !q_empty && ((st == ST_IDLE) || gap_done);
    hold     = (st == ST_IDLE);
    idle     = (st == ST_IDLE);
    cur_bit  = (idx == par_idx) ? par_bit : shreg[0];
    active   = (st == ST_DATA) && tx_en && first_half;
    line_pos = active && cur_bit;
    line_neg = active && !cur_bit;
    bit_clk  = (st != ST_IDLE) && tx_en && first_half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      idx     <= '0;
      gap_cnt <= '0;
      par_bit <= 1'b0;
    end else if (!tx_en) begin
      st <= ST_IDLE;
    end else if (pop) begin
      st      <= ST_DATA;
      shreg   <= q_word;
      idx     <= '0;
      par_bit <= even_par ? (^q_word) : ~(^q_word);
    end else begin
      case (st)
        ST_DATA: begin
          if (bit_end) begin
            if (idx == par_idx) begin
              st      <= ST_GAP;
              gap_cnt <= '0;
            end else begin
              idx   <= idx + 1'b1;
              shreg <= shreg >> 1;
            end
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            st <= ST_IDLE;
          end else if (bit_end) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/a429_tx.sv
module a429_tx
  import a429_tx_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_in,
  input  logic        load_first,
  input  logic        load_second,
  input  logic        tx_en,
  input  logic        fmt_short,
  input  logic        par_even,
  input  logic        rate_slow,
  output logic        line_pos,
  output logic        line_neg,
  output logic        bit_clk,
  output logic        tx_empty
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push;
  logic [WORD_W-1:0] push_word;
  logic              pop;
  logic [WORD_W-1:0] head_word;
  logic              q_empty;
  logic              q_full;
  logic [CNT_W-1:0]  fill;
  logic              hold;
  logic              idle;
  logic              first_half;
  logic              bit_end;

  a429_tx_loader u_loader (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_in       (bus_in),
    .strobe_first (load_first),
    .strobe_second(load_second),
    .accept       (!tx_en),
    .queue_full   (q_full),
    .short_fmt    (fmt_short),
    .push         (push),
    .word         (push_word)
  );

  a429_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .din  (push_word),
    .pop  (pop),
    .dout (head_word),
    .empty(q_empty),
    .full (q_full),
    .fill (fill)
  );

  a429_tx_rate #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .slow      (rate_slow),
    .first_half(first_half),
    .bit_end   (bit_end)
  );

  a429_tx_ser #(.GAP_BITS(GAP_BITS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .short_fmt (fmt_short),
    .even_par  (par_even),
    .q_empty   (q_empty),
    .q_word    (head_word),
    .first_half(first_half),
    .bit_end   (bit_end),
    .pop       (pop),
    .hold      (hold),
    .idle      (idle),
    .line_pos  (line_pos),
    .line_neg  (line_neg),
    .bit_clk   (bit_clk)
  );

  assign tx_empty = q_empty && idle;

endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             line_pos,
  input logic             line_neg,
  input logic             bit_clk,
  input logic             tx_empty,
  input logic [CNT_W-1:0] fill
);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_empty) |=> tx_empty);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg));

  p_first_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos || line_neg) |-> bit_clk);

  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (!line_pos && !line_neg && !bit_clk));

  p_rise_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> (fill == '0));

  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!line_pos && !line_neg && !bit_clk));

endmodule

bind a429_tx a429_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_en   (tx_en),
  .line_pos(line_pos),
  .line_neg(line_neg),
  .bit_clk (bit_clk),
  .tx_empty(tx_empty),
  .fill    (fill)
);

// File: tb/a429_tx_tb_top.sv
module a429_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_in;
  logic        load_first, load_second, tx_en;
  logic        fmt_short, par_even, rate_slow;
  logic        line_pos, line_neg, bit_clk, tx_empty;

  int tests = 0;
  int fails = 0;
  logic [15:0] wf [0:8];
  logic [15:0] ws [0:8];

  always #10 clk = ~clk;

  a429_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .load_first(load_first), .load_second(load_second), .tx_en(tx_en),
    .fmt_short(fmt_short), .par_even(par_even), .rate_slow(rate_slow),
    .line_pos(line_pos), .line_neg(line_neg), .bit_clk(bit_clk),
    .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Serial-order vector, built bit by bit from the mapping stated in R2/R3
  function automatic logic [30:0] ref_word(input logic [15:0] f, input logic [15:0] s,
                                           input logic shrt);
    logic [30:0] v = '0;
    for (int k = 1; k <= 31; k++) begin
      if (k <= 8)       v[k-1] = f[k-1];
      else if (shrt)    v[k-1] = (k <= 24) ? s[k-9] : 1'b0;
      else if (k <= 13) v[k-1] = f[k+2];
      else if (k <= 29) v[k-1] = s[k-14];
      else              v[k-1] = f[k-21];
    end
    return v;
  endfunction

  task automatic load_word(input logic [15:0] f, input logic [15:0] s);
    @(negedge clk); bus_in = f; load_first = 1'b1;
    @(negedge clk); load_first = 1'b0; bus_in = s; load_second = 1'b1;
    @(negedge clk); load_second = 1'b0;
  endtask

  // Enable and compare every cycle of M words against the bit-offset arithmetic
  task automatic run_stream(input int b, input int m, input string tag);
    int div, nb, wl, total, bad_line, bad_clk;
    logic pre_empty;
    div = rate_slow ? 80 : 10;
    nb  = fmt_short ? 24 : 31;
    wl  = nb + 5;
    total = m * wl * div;
    bad_line = 0; bad_clk = 0; pre_empty = 1'b1;
    @(negedge clk); tx_en = 1'b1;
    for (int c = 0; c <= total; c++) begin
      int bt, ph, wi, j, ones;
      logic [30:0] w;
      logic v, ep, en, ec;
      @(negedge clk);
      if (c == total - 1) pre_empty = tx_empty;
      if (c < total) begin
        bt = c / div; ph = c % div; wi = bt / wl; j = bt % wl;
        w = ref_word(wf[b+wi], ws[b+wi], fmt_short);
        ones = 0;
        for (int q = 0; q < nb; q++) ones += int'(w[q]);
        if (j < nb) v = w[j];
        else        v = par_even ? ones[0] : ~ones[0];
        ec = (ph < div / 2);
        ep = (j <= nb) && ec && v;
        en = (j <= nb) && ec && !v;
      end else begin
        ep = 1'b0; en = 1'b0; ec = 1'b0;
      end
      if (line_pos !== ep || line_neg !== en) begin
        if (bad_line == 0)
          $display("  mismatch %s at offset %0d: pos=%b neg=%b exp %b %b", tag, c,
                   line_pos, line_neg, ep, en);
        bad_line++;
      end
      if (bit_clk !== ec) bad_clk++;
    end
    chk(bad_line == 0, {tag, " R6 R7 R8 R9 line waveform mismatches"}, bad_line, 0);
    chk(bad_clk == 0, {tag, " R12 bit_clk mismatches"}, bad_clk, 0);
    chk(pre_empty == 1'b0, {tag, " R10 tx_empty one cycle before end"}, pre_empty, 0);
    chk(tx_empty == 1'b1, {tag, " R10 tx_empty at end of last gap"}, tx_empty, 1);
    tx_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_in = '0; load_first = 1'b0; load_second = 1'b0; tx_en = 1'b0;
    fmt_short = 1'b0; par_even = 1'b0; rate_slow = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R10 R13 tx_empty after reset", tx_empty, 1);
    chk({line_pos, line_neg, bit_clk} == 3'b000, "R13 outputs quiet after reset",
        {line_pos, line_neg, bit_clk}, 0);

    // Sweep every format/parity/rate combination
    for (int cfg = 0; cfg < 8; cfg++) begin
      int n;
      fmt_short = cfg[0]; par_even = cfg[1]; rate_slow = cfg[2];
      n = rate_slow ? 2 : 8;
      for (int i = 0; i < n; i++) begin
        wf[i] = 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(cfg * 16'h0101);
        ws[i] = 16'h3C96 + 16'(i * 16'h0F1D) + 16'(cfg * 16'h2211);
      end
      for (int i = 0; i < n; i++) load_word(wf[i], ws[i]);
      chk(tx_empty == 1'b0, "R1 tx_empty low after loads", tx_empty, 0);
      run_stream(0, n, $sformatf("cfg%0d R2 R3", cfg));
    end

    // R1: repeated first-half strobe keeps only the last value
    fmt_short = 1'b0; par_even = 1'b0; rate_slow = 1'b0;
    @(negedge clk); bus_in = 16'hFFFF; load_first = 1'b1;
    @(negedge clk); load_first = 1'b0;
    wf[0] = 16'h1234; ws[0] = 16'h8001;
    load_word(wf[0], ws[0]);
    run_stream(0, 1, "R1 first-half overwrite");

    // R4: nine loads, only eight sent
    for (int i = 0; i < 9; i++) begin
      wf[i] = 16'h0F0F + 16'(i * 16'h1111);
      ws[i] = 16'hF00D ^ 16'(i * 16'h0731);
      load_word(wf[i], ws[i]);
    end
    run_stream(0, 8, "R4 full queue drops ninth");

    // R5: loads while tx_en is high are ignored
    @(negedge clk); tx_en = 1'b1;
    load_word(16'hDEAD, 16'hBEEF);
    begin
      int busy = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!tx_empty || line_pos || line_neg) busy++;
      end
      chk(busy == 0, "R5 load during tx_en reached queue", busy, 0);
    end
    tx_en = 1'b0;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R5 queue still empty after ignored load", tx_empty, 1);

    // R11: abort mid-word, later words survive
    wf[0] = 16'h00FF; ws[0] = 16'hFFFF;
    wf[1] = 16'h5A5A; ws[1] = 16'h3C3C;
    load_word(wf[0], ws[0]);
    load_word(wf[1], ws[1]);
    @(negedge clk); tx_en = 1'b1;
    for (int c = 0; c <= 50; c++) @(negedge clk);
    chk((line_pos | line_neg) == 1'b1, "R7 line active at bit start", line_pos | line_neg, 1);
    tx_en = 1'b0;
    #1;
    chk({line_pos, line_neg} == 2'b00, "R11 lines drop with tx_en", {line_pos, line_neg}, 0);
    repeat (5) @(negedge clk);
    chk(tx_empty == 1'b0, "R11 queued word kept after abort", tx_empty, 0);
    run_stream(1, 1, "R11 resume with next word");

    // R13: reset empties a loaded queue
    for (int i = 0; i < 3; i++) load_word(16'h1111 * 16'(i + 1), 16'h2222);
    @(negedge clk);
    chk(tx_empty == 1'b0, "R13 queue loaded before reset", tx_empty, 0);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R13 tx_empty after mid-run reset", tx_empty, 1);
    tx_en = 1'b1;
    begin
      int act = 0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (line_pos || line_neg || !tx_empty) act++;
      end
      chk(act == 0, "R13 nothing sent after reset", act, 0);
    end
    tx_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule